// File: doc/BRIEF.md
# Flag-Setting 32-bit Integer ALU

This block is the arithmetic and logic stage of a compact load/store processor. It takes two operands and an operation code. It returns a combinational result and keeps four status flags in a register: negative, zero, carry and overflow. The stored carry flag feeds back as the carry-in of the add-with-carry and subtract-with-carry operations. Wider integers can therefore be processed as a chain of 32-bit steps. A plain add or subtract handles the lowest word, and each higher word uses the carry-consuming form.

Carry follows the inverted-borrow convention: after a subtraction the carry flag is 1 when no borrow occurred. Reverse subtract takes the first operand away from the second. With a second operand of zero it negates a register. The logical operations rewrite only the negative and zero flags. The flag register changes only on a clock edge where the write-flags strobe is high.

Top module: `flag_alu`

## Requirements
- R1: Code 0 (ADD) gives result = A + B. Carry is the unsigned carry out of bit 31. Overflow is set when the signed sum is outside the 32-bit signed range.
- R2: Code 1 (ADC) gives result = A + B + C, where C is the stored carry flag. Carry and overflow follow the R1 rules. An ADD on the low words followed by an ADC on the high words yields the exact 64-bit sum.
- R3: Code 2 (SUB) gives result = A - B. Carry is 1 exactly when A >= B unsigned (no borrow). Overflow is set when the signed difference is outside the 32-bit signed range.
- R4: Code 3 (SBC) gives result = A - B - (1 - C), which equals A + ~B + C. Carry and overflow follow the R3 rules. A SUB on the lowest word followed by an SBC on each higher word yields the exact 96-bit difference.
- R5: Code 4 (RSB) gives result = B - A, with carry and overflow as for a subtraction of A from B. With B = 0 the result is the two's-complement negation of A.
- R6: Codes 5 (AND), 6 (ORR), 7 (EOR) and 8 (BIC) give A & B, A | B, A ^ B and A & ~B respectively.
- R7: When the flags are written by a logical operation (codes 5 to 8), carry and overflow keep their stored values.
- R8: On every flag write by a defined operation (codes 0 to 8), negative becomes result bit 31 and zero becomes 1 exactly when all 32 result bits are 0.
- R9: The flags change only on a rising clock edge where the write-flags strobe is high. With the strobe low, all four flags hold.
- R10: An active-low asynchronous reset clears all four flags to 0.
- R11: Codes 9 to 15 are undefined. They give a result of 0 and leave all four flags unchanged, even with the strobe high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; flags update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code (see R1 to R11) |
| opa_i | input | 32 | First operand A |
| opb_i | input | 32 | Second operand B (immediate value for RSB) |
| flag_we_i | input | 1 | Write-flags strobe |
| result_o | output | 32 | Combinational result |
| n_o | output | 1 | Stored negative flag |
| z_o | output | 1 | Stored zero flag |
| c_o | output | 1 | Stored carry flag |
| v_o | output | 1 | Stored overflow flag |

## Verification
The bench targets the boundaries of the carry and overflow rules:
- 0x7FFFFFFF + 1, where a design that tests unsigned rather than signed range misses overflow.
- 0xFFFFFFFF + 1, where a dropped carry bit loses both carry and zero.
- Equal-operand and 0 - 1 subtractions, where a design using borrow polarity instead of inverted borrow reports the carry backwards.
- Negation of 0x80000000, the one input whose negation overflows.

Random 64-bit add and 96-bit subtract chains expose any design whose ADC or SBC ignores the stored carry, or adds it with the wrong sense: the upper words come out one off. Runs of logical operations after an overflowing add catch a design that clears carry or overflow on a logical flag write. Undefined codes and strobe-low operations catch a design that lets flags drift.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_RSB = 4'd4,
        OP_AND = 4'd5,
        OP_ORR = 4'd6,
        OP_EOR = 4'd7,
        OP_BIC = 4'd8
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } alu_flags_t;

    localparam int unsigned NUM_DEFINED_OPS = 9;

endpackage

// File: rtl/alu_addsub.sv
`timescale 1ns/1ps
// Shared adder for all five arithmetic operations.
// Every operation becomes x + y + cin, with operand inversion chosen per code.
module alu_addsub
    import alu_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  alu_op_e          op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_o,
    output logic             ovf_o
);
    localparam int unsigned MSB = WIDTH - 1;

    logic [WIDTH-1:0] x_d;
    logic [WIDTH-1:0] y_d;
    logic             cin_d;
    logic [WIDTH:0]   full_d;

    always_comb begin
        x_d   = a_i;
        y_d   = b_i;
        cin_d = 1'b0;
        unique case (op_i)
            OP_ADC: cin_d = carry_i;
            OP_SUB: begin
                y_d   = ~b_i;
                cin_d = 1'b1;
            end
            OP_SBC: begin
                y_d   = ~b_i;
                cin_d = carry_i;
            end
            OP_RSB: begin
                x_d   = b_i;
                y_d   = ~a_i;
                cin_d = 1'b1;
            end
            default: ;
        endcase
        full_d  = {1'b0, x_d} + {1'b0, y_d} + {{WIDTH{1'b0}}, cin_d};
        sum_o   = full_d[WIDTH-1:0];
        carry_o = full_d[WIDTH];
        // Signed overflow: both adder inputs share a sign that the sum lacks.
        ovf_o   = (x_d[MSB] == y_d[MSB]) && (full_d[MSB] != x_d[MSB]);
    end

endmodule

// File: rtl/alu_logic.sv
`timescale 1ns/1ps
// Bitwise unit, one slice per bit.
module alu_logic
    import alu_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  alu_op_e          op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] res_o
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_comb begin
            unique case (op_i)
                OP_AND:  res_o[i] = a_i[i] & b_i[i];
                OP_ORR:  res_o[i] = a_i[i] | b_i[i];
                OP_EOR:  res_o[i] = a_i[i] ^ b_i[i];
                OP_BIC:  res_o[i] = a_i[i] & ~b_i[i];
                default: res_o[i] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/flag_alu.sv
`timescale 1ns/1ps
module flag_alu
    import alu_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       op_i,
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    input  logic             flag_we_i,
    output logic [WIDTH-1:0] result_o,
    output logic             n_o,
    output logic             z_o,
    output logic             c_o,
    output logic             v_o
);
    localparam int unsigned MSB = WIDTH - 1;

    typedef struct packed {
        alu_flags_t flags;
    } state_t;

    state_t           st_d;
    state_t           st_q;
    alu_op_e          op;
    logic             is_arith;
    logic             is_logic;
    logic [WIDTH-1:0] arith_res;
    logic             arith_c;
    logic             arith_v;
    logic [WIDTH-1:0] logic_res;

    assign op       = alu_op_e'(op_i);
    assign is_arith = (op_i <= 4'd4);
    assign is_logic = (op_i >= 4'd5) && (op_i < 4'(NUM_DEFINED_OPS));

    alu_addsub #(.WIDTH(WIDTH)) i_addsub (
        .op_i    (op),
        .a_i     (opa_i),
        .b_i     (opb_i),
        .carry_i (st_q.flags.c),
        .sum_o   (arith_res),
        .carry_o (arith_c),
        .ovf_o   (arith_v)
    );

    alu_logic #(.WIDTH(WIDTH)) i_logic (
        .op_i  (op),
        .a_i   (opa_i),
        .b_i   (opb_i),
        .res_o (logic_res)
    );

    always_comb begin
        st_d     = st_q;
        result_o = '0;
        if (is_arith)      result_o = arith_res;
        else if (is_logic) result_o = logic_res;

        if (flag_we_i && (is_arith || is_logic)) begin
            st_d.flags.n = result_o[MSB];
            st_d.flags.z = (result_o == '0);
            if (is_arith) begin
                st_d.flags.c = arith_c;
                st_d.flags.v = arith_v;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign n_o = st_q.flags.n;
    assign z_o = st_q.flags.z;
    assign c_o = st_q.flags.c;
    assign v_o = st_q.flags.v;

    // ---------------- assertions ----------------
    p_add_carry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we_i && op_i == 4'd0) |=> (c_o == ($past(result_o) < $past(opa_i))));

    p_sub_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we_i && op_i == 4'd2) |=> (c_o == ($past(opa_i) >= $past(opb_i))));

    p_logic_keeps_cv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we_i && is_logic) |=> (c_o == $past(c_o) && v_o == $past(v_o)));

    p_nz_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we_i && (is_arith || is_logic)) |=>
            (n_o == $past(result_o[MSB]) && z_o == ($past(result_o) == '0)));

    p_hold_no_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we_i |=> $stable({n_o, z_o, c_o, v_o}));

    p_reset_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ({n_o, z_o, c_o, v_o} == 4'b0000));

    p_undef_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i >= 4'(NUM_DEFINED_OPS)) |-> (result_o == '0));

    p_undef_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i >= 4'(NUM_DEFINED_OPS)) |=> $stable({n_o, z_o, c_o, v_o}));

endmodule

// File: tb/test_flag_alu.sv
`timescale 1ns/1ps
module test_flag_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op = 4'd0;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic        we = 1'b0;
    logic [31:0] result;
    logic        n, z, c, v;

    int checks = 0;
    int fails  = 0;
    logic mn = 0, mz = 0, mc = 0, mv = 0;   // model flags

    always #2 clk = ~clk;   // 250 MHz

    flag_alu i_flag_alu (
        .clk(clk), .rst_n(rst_n), .op_i(op), .opa_i(a), .opb_i(b),
        .flag_we_i(we), .result_o(result), .n_o(n), .z_o(z), .c_o(c), .v_o(v)
    );

    task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic string op_tag(input logic [3:0] o);
        case (o)
            4'd0: return "R1 add";
            4'd1: return "R2 adc";
            4'd2: return "R3 sub";
            4'd3: return "R4 sbc";
            4'd4: return "R5 rsb";
            4'd5, 4'd6, 4'd7, 4'd8: return "R6 logic";
            default: return "R11 undefined";
        endcase
    endfunction

    // Reference from the requirements: wide signed/unsigned arithmetic.
    // Returns {result, carry, overflow}.
    function automatic logic [33:0] ref_arith(input logic [3:0] o, input logic [31:0] x,
                                              input logic [31:0] y, input logic cf);
        longint ux = longint'(x), uy = longint'(y);
        longint sx = longint'($signed(x)), sy = longint'($signed(y));
        longint us, ss;
        logic   cout;
        case (o)
            4'd0: begin us = ux + uy;               ss = sx + sy;               cout = us > 64'sd4294967295; end
            4'd1: begin us = ux + uy + longint'(cf); ss = sx + sy + longint'(cf); cout = us > 64'sd4294967295; end
            4'd2: begin us = ux - uy;               ss = sx - sy;               cout = us >= 0; end
            4'd3: begin us = ux - uy - longint'(!cf); ss = sx - sy - longint'(!cf); cout = us >= 0; end
            default: begin us = uy - ux;            ss = sy - sx;               cout = us >= 0; end
        endcase
        return {us[31:0], cout, (ss > 64'sd2147483647) || (ss < -64'sd2147483648)};
    endfunction

    task automatic do_op(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                         input logic w, output logic [31:0] r);
        logic [31:0] er;
        logic [33:0] ar;
        @(negedge clk);
        op = o; a = x; b = y; we = w;
        #1;
        ar = ref_arith(o, x, y, mc);
        case (o)
            4'd0, 4'd1, 4'd2, 4'd3, 4'd4: er = ar[33:2];
            4'd5: er = x & y;
            4'd6: er = x | y;
            4'd7: er = x ^ y;
            4'd8: er = x & ~y;
            default: er = 32'd0;
        endcase
        chk(op_tag(o), {4'd0, result}, {4'd0, er});
        r = result;
        if (w && o <= 4'd8) begin
            mn = er[31];
            mz = (er == 32'd0);
            if (o <= 4'd4) begin mc = ar[1]; mv = ar[0]; end
        end
        @(posedge clk);
        #1;
        we = 1'b0;
        chk(!w ? "R9 hold" : (o > 4'd8) ? "R11 flags" : (o >= 4'd5) ? "R7 R8 logic flags"
                                                                      : "R8 arith flags",
            {32'd0, n, z, c, v}, {32'd0, mn, mz, mc, mv});
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] r0, r1, r2;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R10 reset", {32'd0, n, z, c, v}, 36'd0);

        // Directed corners
        do_op(4'd0, 32'h7FFF_FFFF, 32'd1, 1'b1, r0);   // R1 signed overflow
        do_op(4'd5, 32'hFFFF_0000, 32'h0F0F_0F0F, 1'b1, r0); // R7 keep V
        do_op(4'd0, 32'hFFFF_FFFF, 32'd1, 1'b1, r0);   // R1 carry + zero
        do_op(4'd8, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, r0); // R6 BIC -> zero, R7 keep C
        do_op(4'd2, 32'd1234, 32'd1234, 1'b1, r0);     // R3 equal: C=1, Z=1
        do_op(4'd2, 32'd0, 32'd1, 1'b1, r0);           // R3 borrow: C=0, N=1
        do_op(4'd4, 32'd5, 32'd0, 1'b1, r0);           // R5 negate 5
        chk("R5 negate", {4'd0, r0}, {4'd0, 32'hFFFF_FFFB});
        do_op(4'd4, 32'h8000_0000, 32'd0, 1'b1, r0);   // R5 overflowing negate
        do_op(4'd0, 32'h1, 32'h1, 1'b0, r0);           // R9 no strobe
        do_op(4'd12, 32'hDEAD_BEEF, 32'h1, 1'b1, r0);  // R11
        do_op(4'd15, 32'h0, 32'h0, 1'b1, r0);          // R11
        do_op(4'd6, 32'h0, 32'h0, 1'b1, r0);           // R8 zero via OR
        do_op(4'd7, 32'hA5A5_A5A5, 32'h5A5A_5A5A, 1'b1, r0); // R6 EOR

        // 64-bit add chains (R2)
        for (int k = 0; k < 40; k++) begin
            logic [63:0] x, y;
            logic [64:0] s;
            x = {$urandom, $urandom};
            y = {$urandom, $urandom};
            if (k == 0) begin x = 64'h0000_0001_FFFF_FFFF; y = 64'd1; end
            s = {1'b0, x} + {1'b0, y};
            do_op(4'd0, x[31:0], y[31:0], 1'b1, r0);
            do_op(4'd1, x[63:32], y[63:32], 1'b1, r1);
            chk("R2 64-bit sum", {r1[3:0], r1, r0} >> 32 == 0 ? 36'd0 : {4'd0, r1}, {4'd0, s[63:32]});
            chk("R2 64-bit low", {4'd0, r0}, {4'd0, s[31:0]});
            chk("R2 64-bit carry", {35'd0, c}, {35'd0, s[64]});
        end

        // 96-bit subtract chains (R4)
        for (int k = 0; k < 40; k++) begin
            logic [95:0] x, y, d;
            x = {$urandom, $urandom, $urandom};
            y = {$urandom, $urandom, $urandom};
            if (k == 0) begin x = 96'h1_0000_0000_0000_0000; y = 96'd1; end
            d = x - y;
            do_op(4'd2, x[31:0], y[31:0], 1'b1, r0);
            do_op(4'd3, x[63:32], y[63:32], 1'b1, r1);
            do_op(4'd3, x[95:64], y[95:64], 1'b1, r2);
            chk("R4 96-bit diff", {4'd0, r2}, {4'd0, d[95:64]});
            chk("R4 96-bit mid", {4'd0, r1}, {4'd0, d[63:32]});
            chk("R4 96-bit low", {4'd0, r0}, {4'd0, d[31:0]});
            chk("R4 no-borrow carry", {35'd0, c}, {35'd0, x >= y});
        end

        // Random mix of all codes
        for (int k = 0; k < 400; k++) begin
            logic [3:0]  o;
            logic [31:0] x, y;
            o = ($urandom % 8 == 0) ? 4'($urandom % 16) : 4'($urandom % 9);
            x = $urandom;
            y = ($urandom % 6 == 0) ? x : $urandom;
            do_op(o, x, y, ($urandom % 5) != 0, r0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule